// File: doc/BRIEF.md
# I2C Controller Interrupt Status Collector

This block gathers the twelve event sources of an I2C controller into a raw status vector. It applies a software mask to that vector and drives a single interrupt line. Most sources are sticky: a one-cycle pulse on the event input sets the bit, and the bit stays set until software reads the clear register that belongs to that source, or the combined clear register. Two sources, receive-queue-full and transmit-queue-empty, are levels that follow the queue conditions directly, and no read clears them.

Each source has its own clear register, so clearing one source cannot lose an event that arrives for another. When a transfer aborts, a cause vector arrives with the abort pulse and is ORed into an abort-cause register. Only a read of the abort source's own clear register empties that register, so the combined clear leaves the cause intact. Software reaches the block through a simple read port with a registered result, plus a write strobe for the mask.

Top module: `i2c_irq_collect`

## Requirements
- R1: Raw status bit positions are: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop detected, 10 start detected, 11 general call. The raw vector is read at address 0.
- R2: The masked status (address 1) equals raw AND mask. `irq` is the OR of the masked status. The mask is read at address 2 and is loaded from `mask_wdata` when `mask_we` is high.
- R3: After reset the mask is 0x054, which enables receive full, transmit empty and transmit abort. `rd_data` is 0 and no latched bit or cause bit is set.
- R4: A pulse on `evt_pulse[i]` for any source except 2 and 4 sets raw bit i at the next edge. The bit stays set until a clear read takes effect.
- R5: A read at address 8+i returns the pre-read value of raw bit i in bit 0 and clears only raw bit i. Every other source is left as it was.
- R6: A read at address 4 returns the pre-read raw vector and clears every latched source at once.
- R7: Raw bits 2 and 4 always equal `rx_full_lvl` and `tx_empty_lvl`. Clear reads (addresses 4, 10, 12) have no effect on them.
- R8: If a source's pulse arrives in the same cycle as a clear read of that source, the bit is set after the edge.
- R9: A pulse on `evt_pulse[6]` ORs `abort_cause_in` into the abort-cause register (address 3). Only defined cause bits are kept (mask 0xEBF): 0 seven-bit address NACK, 1 first ten-bit address byte NACK, 2 second ten-bit address byte NACK, 3 data NACK, 4 general call NACK, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart disabled, 10 ten-bit read with restart disabled, 11 use while disabled.
- R10: Only a read at address 14 (the transmit abort clear) empties the abort-cause register, and a capture in the same cycle survives that clear. The combined clear leaves the cause untouched.
- R11: `rd_data` is registered. It shows the result of a read in the cycle after `rd_en`, and it is 0 for cycles without `rd_en` and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 12 | Single-cycle event pulses, one per source |
| rx_full_lvl | input | 1 | Receive-queue-full level |
| tx_empty_lvl | input | 1 | Transmit-queue-empty level |
| abort_cause_in | input | 12 | Abort cause vector, sampled with evt_pulse[6] |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 12 | New mask value |
| rd_en | input | 1 | Read strobe (reads of clear addresses clear) |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Registered read result |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: a 5-bit address and 32-bit read data. At these widths every mapped register can be reached, and so can unmapped addresses up to 31. Random stimulus mixes sparse pulses, toggling levels and reads of all 32 addresses, so clear reads regularly coincide with pulses on the same source and abort captures coincide with the abort clear. Directed steps pin down the reset mask, the stickiness of the abort cause across the combined clear, and the immunity of the level sources to clear reads.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NSRC = 12;

    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT  = 6;

    localparam logic [NSRC-1:0] LEVEL_SRC   = 12'h014;
    localparam logic [NSRC-1:0] MASK_RESET  = 12'h054;
    localparam logic [NSRC-1:0] CAUSE_VALID = 12'hEBF;

    localparam int ADDR_RAW     = 0;
    localparam int ADDR_MASKED  = 1;
    localparam int ADDR_MASK    = 2;
    localparam int ADDR_CAUSE   = 3;
    localparam int ADDR_CLR_ALL = 4;
    localparam int ADDR_CLR_ONE = 8;

    typedef struct packed {
        logic [NSRC-1:0] clr;
        logic            cause_clr;
    } clr_req_t;

    function automatic logic is_level(input int idx);
        return LEVEL_SRC[idx];
    endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import i2c_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pulse,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (is_level(i)) begin : g_level
            assign raw[i] = lvl[i];
        end else begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= (q & ~clr[i]) | pulse[i];
            end
            assign raw[i] = q;

            p_pulse_sets_r4: assert property (@(posedge clk) disable iff (rst)
                pulse[i] |=> raw[i]);
            p_clear_drops_r5: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !pulse[i]) |=> !raw[i]);
            p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && pulse[i]) |=> raw[i]);
        end
    end
endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause
    import i2c_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [N-1:0] cause_in,
    input  logic         clear,
    output logic [N-1:0] cause
);
    logic [N-1:0] kept;
    assign kept = cause_in & CAUSE_VALID[N-1:0];

    always_ff @(posedge clk) begin
        if (rst) cause <= '0;
        else     cause <= (clear ? '0 : cause) | (capture ? kept : '0);
    end

    p_cause_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clear && !capture) |=> (cause == '0));
    p_cause_capture_r9: assert property (@(posedge clk) disable iff (rst)
        capture |=> ((cause & $past(kept)) == $past(kept)));
    p_cause_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!clear && !capture) |=> $stable(cause));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int N      = NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N-1:0]      raw,
    input  logic [N-1:0]      mask,
    input  logic [N-1:0]      cause,
    output clr_req_t          req,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_next;
    logic [N-1:0]      hit_one;
    logic              hit_all;

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hit_one[i] = rd_en && (int'(rd_addr) == ADDR_CLR_ONE + i);
    end
    assign hit_all = rd_en && (int'(rd_addr) == ADDR_CLR_ALL);

    always_comb begin
        req.clr       = (hit_one | {N{hit_all}}) & ~LEVEL_SRC[N-1:0];
        req.cause_clr = hit_one[SRC_TX_ABRT];
    end

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            case (int'(rd_addr))
                ADDR_RAW:     rd_next[N-1:0] = raw;
                ADDR_MASKED:  rd_next[N-1:0] = raw & mask;
                ADDR_MASK:    rd_next[N-1:0] = mask;
                ADDR_CAUSE:   rd_next[N-1:0] = cause;
                ADDR_CLR_ALL: rd_next[N-1:0] = raw;
                default:      rd_next[0]     = |(hit_one & raw);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));
    p_one_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_one) <= 1);
endmodule

// File: rtl/i2c_irq_collect.sv
module i2c_irq_collect
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic              rx_full_lvl,
    input  logic              tx_empty_lvl,
    input  logic [NSRC-1:0]   abort_cause_in,
    input  logic              mask_we,
    input  logic [NSRC-1:0]   mask_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NSRC-1:0] lvl, raw, mask_q, cause;
    clr_req_t        req;

    always_comb begin
        lvl               = '0;
        lvl[SRC_RX_FULL]  = rx_full_lvl;
        lvl[SRC_TX_EMPTY] = tx_empty_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= MASK_RESET;
        else if (mask_we) mask_q <= mask_wdata;
    end

    irq_src_bank #(.N(NSRC)) u_bank (
        .clk(clk), .rst(rst), .pulse(evt_pulse), .lvl(lvl),
        .clr(req.clr), .raw(raw)
    );

    irq_abort_cause #(.N(NSRC)) u_cause (
        .clk(clk), .rst(rst), .capture(evt_pulse[SRC_TX_ABRT]),
        .cause_in(abort_cause_in), .clear(req.cause_clr), .cause(cause)
    );

    irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NSRC)) u_port (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .raw(raw), .mask(mask_q), .cause(cause), .req(req), .rd_data(rd_data)
    );

    assign irq = |(raw & mask_q);

    p_mask_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == MASK_RESET));
    p_irq_level_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_full_lvl && mask_q[SRC_RX_FULL]) |-> irq);
    p_irq_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
endmodule

// File: tb/i2c_irq_collect_bench.sv
module i2c_irq_collect_bench;
    localparam logic [11:0] LVL_M   = 12'h014;
    localparam logic [11:0] VALID_M = 12'hEBF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] evt_pulse = '0, abort_cause_in = '0, mask_wdata = '0;
    logic        rx_full_lvl = 1'b0, tx_empty_lvl = 1'b0, mask_we = 1'b0, rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0, failures = 0;
    logic [11:0] m_lat = '0, m_mask = 12'h054, m_cause = '0;

    always #2 clk = ~clk;

    i2c_irq_collect u_i2c_irq_collect (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .rx_full_lvl(rx_full_lvl),
        .tx_empty_lvl(tx_empty_lvl), .abort_cause_in(abort_cause_in),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [11:0] raw_now();
        logic [11:0] l;
        l = '0; l[2] = rx_full_lvl; l[4] = tx_empty_lvl;
        return (m_lat & ~LVL_M) | l;
    endfunction

    function automatic logic [31:0] exp_read(input logic en, input int a);
        logic [11:0] r;
        r = raw_now();
        if (!en) return '0;
        if (a == 0 || a == 4) return {20'b0, r};
        if (a == 1) return {20'b0, r & m_mask};
        if (a == 2) return {20'b0, m_mask};
        if (a == 3) return {20'b0, m_cause};
        if (a >= 8 && a < 20) return {31'b0, r[a-8]};
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic [11:0] p, input logic [11:0] c,
                       input logic we, input logic [11:0] wd, input logic en, input int a);
        logic [31:0] er;
        logic [11:0] clr;
        evt_pulse = p; abort_cause_in = c; mask_we = we; mask_wdata = wd;
        rd_en = en; rd_addr = 5'(a);
        er  = exp_read(en, a);
        clr = '0;
        if (en && a == 4) clr = '1;
        if (en && a >= 8 && a < 20) clr[a-8] = 1'b1;
        clr &= ~LVL_M;
        m_lat   = (m_lat & ~clr) | (p & ~LVL_M);
        m_cause = ((en && a == 14) ? 12'h000 : m_cause) | (p[6] ? (c & VALID_M) : 12'h000);
        if (we) m_mask = wd;
        @(posedge clk); #1;
        check({tag, " rd_data"}, rd_data, er);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, |(raw_now() & m_mask)});
        @(negedge clk);
        evt_pulse = '0; mask_we = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R3 reset rd_data", rd_data, 32'h0);
        check("R3 reset irq", {31'b0, irq}, 32'h0);
        cyc("R3 mask reset", '0, '0, 0, '0, 1, 2);
        cyc("R11 read latency", '0, '0, 0, '0, 1, 2);
        cyc("R4 pulse", 12'h201, '0, 0, '0, 0, 0);
        cyc("R1 raw bit order", '0, '0, 0, '0, 1, 0);
        cyc("R5 own clear", '0, '0, 0, '0, 1, 8);
        cyc("R5 other kept", '0, '0, 0, '0, 1, 0);
        cyc("R8 pulse with clear", 12'h008, '0, 0, '0, 1, 11);
        cyc("R8 stays set", '0, '0, 0, '0, 1, 0);
        rx_full_lvl = 1'b1;
        cyc("R7 level follows", '0, '0, 0, '0, 1, 0);
        cyc("R7 clear ignored", '0, '0, 0, '0, 1, 10);
        cyc("R7 level kept", '0, '0, 0, '0, 1, 0);
        cyc("R2 mask write", '0, '0, 1, 12'h200, 0, 0);
        cyc("R2 masked read", '0, '0, 0, '0, 1, 1);
        cyc("R9 cause capture", 12'h040, 12'hFFF, 0, '0, 0, 0);
        cyc("R9 cause read", 12'h040, 12'h001, 0, '0, 1, 3);
        cyc("R6 clear all", '0, '0, 0, '0, 1, 4);
        cyc("R6 after clear all", '0, '0, 0, '0, 1, 0);
        cyc("R10 cause survives clear all", '0, '0, 0, '0, 1, 3);
        cyc("R10 abort clear", '0, '0, 0, '0, 1, 14);
        cyc("R10 cause empty", '0, '0, 0, '0, 1, 3);
        cyc("R10 capture beats clear", 12'h040, 12'h208, 0, '0, 1, 14);
        cyc("R10 capture kept", '0, '0, 0, '0, 1, 3);
        cyc("R11 unmapped", '0, '0, 0, '0, 1, 31);
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] p;
            p = 12'($urandom) & 12'($urandom) & 12'($urandom);
            if ($urandom_range(0, 9) == 0) rx_full_lvl = ~rx_full_lvl;
            if ($urandom_range(0, 9) == 0) tx_empty_lvl = ~tx_empty_lvl;
            cyc("RND R4 R5 R6 R8 R9", p, 12'($urandom),
                $urandom_range(0, 15) == 0, 12'($urandom),
                $urandom_range(0, 3) != 0, int'($urandom_range(0, 31)));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule